// File: doc/BRIEF.md
# Audio Link Output Frame Serializer

This block produces the outgoing serial stream of a codec audio link. Every 256 bit times it sends one frame: a 16-bit tag slot followed by twelve 20-bit data slots. The tag says which slots carry data. Slot 1 holds a register command, slot 2 holds the command's write data, and slots 3 and 4 hold a left and a right playback sample. The remaining eight slots are always zero. The frame leaves most significant bit first, one bit per rising edge of the bit clock. A frame sync output is high during the tag and low for the rest of the frame.

The user side offers a command (read/write flag, 7-bit address, 16-bit write data) with a valid flag, and a left/right sample pair with its own valid flag. Both are sampled only on the edge that starts a frame. A one-cycle ready pulse tells the user that the offer was taken into that frame. When nothing is offered, the frame goes out all zero. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame lasts 256 bit clocks. `sync_o` is high for the first 16 bit times of every frame and low for the remaining 240. Frames follow each other without gaps.
- R2: `sdata_o` carries the frame most significant bit first: tag bits 15..0, then slot 1 through slot 12, each from bit 19 down to bit 0. Slots 5 to 12 (the last 160 bit times) are always 0.
- R3: Tag bit 15 is 1 when any slot is valid. Tag bit 14 marks slot 1 and is set for an accepted command. Tag bit 13 marks slot 2 and is set for an accepted write command. Tag bits 12 and 11 mark slots 3 and 4 and are set for an accepted sample pair. Tag bits 10..0 are 0.
- R4: Slot 1 carries the read flag in bit 19 (1 = read, 0 = write) and the register address in bits 18..12. Bits 11..0 are 0. The slot is all zero when no command was accepted.
- R5: For an accepted write command, slot 2 carries the write data in bits 19..4, and bits 3..0 are 0.
- R6: For an accepted read command, all of slot 2 is 0 and its tag bit is 0, whatever the write-data input holds.
- R7: Slot 3 carries the left sample and slot 4 carries the right sample, each in bits 19..4 with bits 3..0 at 0. Both slots are zero when no sample pair was accepted.
- R8: Inputs are sampled only on the edge that starts a frame. The values present on that edge are the ones sent, and changes at any other time have no effect. `cmd_ready_o` and `pcm_ready_o` are high for exactly the first bit time of a frame that carries an accepted command or sample pair, and are low at all other times.
- R9: A frame with neither a command nor a sample pair accepted is all zero, its tag included.
- R10: While reset is asserted, `sdata_o`, `sync_o` and both ready outputs are 0. The first frame starts on the third rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_rd_i | input | 1 | 1 = read command, 0 = write |
| cmd_addr_i | input | 7 | Register address |
| cmd_wdata_i | input | 16 | Register write data |
| cmd_ready_o | output | 1 | Command taken into the current frame (pulse) |
| pcm_valid_i | input | 1 | Sample pair offered |
| pcm_left_i | input | 16 | Left playback sample |
| pcm_right_i | input | 16 | Right playback sample |
| pcm_ready_o | output | 1 | Sample pair taken into the current frame (pulse) |
| sdata_o | output | 1 | Serial frame data |
| sync_o | output | 1 | Frame sync |

## Verification
The inputs that count are the ones present on a frame-start edge. That edge is the third one after reset release and every 256th one after it. The first frame bit, the raised sync and the ready pulses all appear in the bit time that follows that edge, and frame bit k appears k bit times later. The reference model records the inputs on every rising edge. At each frame start it builds the whole expected frame from the recorded values as a bit queue. On each falling edge it pops one bit and compares it against data, sync and both ready outputs. Offers made or changed in the middle of a frame are therefore checked to show up only in the next frame.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  // Default link geometry
  localparam int unsigned TAG_BITS   = 16;
  localparam int unsigned SLOT_BITS  = 20;
  localparam int unsigned SLOT_COUNT = 12;
  localparam int unsigned SAMPLE_BITS = 16;
  localparam int unsigned REG_ADDR_BITS = 7;
  // Number of leading data slots that can carry content
  localparam int unsigned LIVE_SLOTS = 4;

  // Index of each live slot (0-based, slot 1 of the link is index 0)
  typedef enum logic [1:0] {
    SL_CMD   = 2'd0,
    SL_WDATA = 2'd1,
    SL_LEFT  = 2'd2,
    SL_RIGHT = 2'd3
  } slot_id_e;
endpackage

// File: rtl/aclink_rst_sync.sv
module aclink_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer #(
  parameter int unsigned FRAME_W = 256,
  parameter int unsigned TAG_W   = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic load_o,
  output logic sync_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] TAG_END = CNT_W'(TAG_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  // Reset parks the counter on the last bit so the first edge out of reset loads
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= LAST;
    else          cnt_q <= cnt_d;
  end

  assign load_o = (cnt_q == LAST);
  assign sync_o = (cnt_q < TAG_END);

  // R1
  sync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(sync_o) |-> (cnt_q == '0));
endmodule

// File: rtl/aclink_frame_build.sv
module aclink_frame_build
  import aclink_tx_pkg::*;
#(
  parameter int unsigned TAG_W   = TAG_BITS,
  parameter int unsigned SLOT_W  = SLOT_BITS,
  parameter int unsigned N_SLOTS = SLOT_COUNT,
  parameter int unsigned SAMP_W  = SAMPLE_BITS,
  parameter int unsigned ADDR_W  = REG_ADDR_BITS,
  localparam int unsigned FRAME_W = TAG_W + SLOT_W * N_SLOTS
) (
  input  logic              cmd_take_i,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [SAMP_W-1:0] cmd_wdata_i,
  input  logic              pcm_take_i,
  input  logic [SAMP_W-1:0] pcm_left_i,
  input  logic [SAMP_W-1:0] pcm_right_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned LOW_PAD  = SLOT_W - SAMP_W;
  localparam int unsigned ADDR_PAD = SLOT_W - 1 - ADDR_W;
  localparam int unsigned TAG_PAD  = TAG_W - 1 - LIVE_SLOTS;

  logic [LIVE_SLOTS-1:0] live;
  logic [SLOT_W-1:0]     slot_w [N_SLOTS];
  logic                  is_write;

  assign is_write = cmd_take_i && !cmd_rd_i;

  // Valid flags in tag order: slot 1 first (highest tag bit below the frame flag)
  always_comb begin
    live[LIVE_SLOTS-1-SL_CMD]   = cmd_take_i;
    live[LIVE_SLOTS-1-SL_WDATA] = is_write;
    live[LIVE_SLOTS-1-SL_LEFT]  = pcm_take_i;
    live[LIVE_SLOTS-1-SL_RIGHT] = pcm_take_i;
  end

  assign frame_o[FRAME_W-1 -: TAG_W] = {(|live), live, {TAG_PAD{1'b0}}};

  genvar s;
  generate
    for (s = 0; s < N_SLOTS; s++) begin : g_slot
      if (s == SL_CMD) begin : g_cmd
        assign slot_w[s] = cmd_take_i ? {cmd_rd_i, cmd_addr_i, {ADDR_PAD{1'b0}}} : '0;
      end else if (s == SL_WDATA) begin : g_wd
        assign slot_w[s] = is_write ? {cmd_wdata_i, {LOW_PAD{1'b0}}} : '0;
      end else if (s == SL_LEFT) begin : g_l
        assign slot_w[s] = pcm_take_i ? {pcm_left_i, {LOW_PAD{1'b0}}} : '0;
      end else if (s == SL_RIGHT) begin : g_r
        assign slot_w[s] = pcm_take_i ? {pcm_right_i, {LOW_PAD{1'b0}}} : '0;
      end else begin : g_pad
        assign slot_w[s] = '0;
      end
      assign frame_o[FRAME_W-TAG_W-1-s*SLOT_W -: SLOT_W] = slot_w[s];
    end
  endgenerate
endmodule

// File: rtl/aclink_shift_out.sv
module aclink_shift_out #(
  parameter int unsigned FRAME_W = 256,
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned PAD_W   = 160,
  parameter int unsigned LIVE_N  = 4
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] frame_q, frame_d;

  always_comb begin
    if (load_i) frame_d = frame_i;
    else        frame_d = {frame_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) frame_q <= '0;
    else          frame_q <= frame_d;
  end

  assign sdata_o = frame_q[FRAME_W-1];

  // R2
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |=> (frame_q[PAD_W-1:0] == '0));

  // R3
  tag_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |=> (frame_q[FRAME_W-1] == (|frame_q[FRAME_W-2 -: LIVE_N])));

  // R9
  idle_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |=> ((frame_q[FRAME_W-2 -: TAG_W-1] == '0) -> !frame_q[FRAME_W-1]));
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int unsigned TAG_W   = TAG_BITS,
  parameter int unsigned SLOT_W  = SLOT_BITS,
  parameter int unsigned N_SLOTS = SLOT_COUNT,
  parameter int unsigned SAMP_W  = SAMPLE_BITS,
  parameter int unsigned ADDR_W  = REG_ADDR_BITS
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [SAMP_W-1:0] cmd_wdata_i,
  output logic              cmd_ready_o,
  input  logic              pcm_valid_i,
  input  logic [SAMP_W-1:0] pcm_left_i,
  input  logic [SAMP_W-1:0] pcm_right_i,
  output logic              pcm_ready_o,
  output logic              sdata_o,
  output logic              sync_o
);
  localparam int unsigned FRAME_W = TAG_W + SLOT_W * N_SLOTS;
  localparam int unsigned PAD_W   = SLOT_W * (N_SLOTS - LIVE_SLOTS);

  logic               rst_n;
  logic               load;
  logic               cmd_take, pcm_take;
  logic               cmd_rdy_q, cmd_rdy_d;
  logic               pcm_rdy_q, pcm_rdy_d;
  logic [FRAME_W-1:0] frame_w;

  aclink_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  aclink_bit_timer #(.FRAME_W(FRAME_W), .TAG_W(TAG_W)) u_timer (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .load_o  (load),
    .sync_o  (sync_o)
  );

  assign cmd_take = load && cmd_valid_i;
  assign pcm_take = load && pcm_valid_i;

  aclink_frame_build #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS),
    .SAMP_W(SAMP_W), .ADDR_W(ADDR_W)
  ) u_build (
    .cmd_take_i  (cmd_take),
    .cmd_rd_i    (cmd_rd_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .pcm_take_i  (pcm_take),
    .pcm_left_i  (pcm_left_i),
    .pcm_right_i (pcm_right_i),
    .frame_o     (frame_w)
  );

  aclink_shift_out #(
    .FRAME_W(FRAME_W), .TAG_W(TAG_W), .PAD_W(PAD_W), .LIVE_N(LIVE_SLOTS)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .load_i  (load),
    .frame_i (frame_w),
    .sdata_o (sdata_o)
  );

  always_comb begin
    cmd_rdy_d = cmd_take;
    pcm_rdy_d = pcm_take;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cmd_rdy_q <= 1'b0;
      pcm_rdy_q <= 1'b0;
    end else begin
      cmd_rdy_q <= cmd_rdy_d;
      pcm_rdy_q <= pcm_rdy_d;
    end
  end

  assign cmd_ready_o = cmd_rdy_q;
  assign pcm_ready_o = pcm_rdy_q;

  // R8
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_ready_o |=> !cmd_ready_o);

  // R8
  ready_in_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_ready_o || pcm_ready_o) |-> sync_o);

  // R1
  load_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    load |=> sync_o);
endmodule

// File: tb/aclink_tx_framer_tb.sv
`timescale 1ns/1ps
module aclink_tx_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_rd;
  logic [6:0]  cmd_addr;
  logic [15:0] cmd_wdata, pcm_left, pcm_right;
  logic        pcm_valid;
  logic        cmd_ready, pcm_ready, sdata, sync;

  always #5 clk = ~clk;

  aclink_tx_framer dut_i (
    .clk_i(clk), .rst_n_i(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_rd_i(cmd_rd), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .cmd_ready_o(cmd_ready),
    .pcm_valid_i(pcm_valid), .pcm_left_i(pcm_left), .pcm_right_i(pcm_right),
    .pcm_ready_o(pcm_ready), .sdata_o(sdata), .sync_o(sync)
  );

  int total = 0;
  int bad   = 0;
  int edge_n = 0;
  logic        s_cv, s_rd, s_pv;
  logic [6:0]  s_addr;
  logic [15:0] s_wd, s_l, s_r;
  bit          exp_q[$];
  bit          fr_read, fr_idle;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected frame written straight from the requirement text
  function automatic logic [255:0] build_frame();
    logic [255:0] f = '0;
    if (s_cv) begin
      f[255] = 1'b1; f[254] = 1'b1;              // R3
      f[239] = s_rd;                             // R4
      f[238:232] = s_addr;
      if (!s_rd) begin
        f[253] = 1'b1;
        f[219:204] = s_wd;                       // R5
      end
    end
    if (s_pv) begin
      f[255] = 1'b1; f[252] = 1'b1; f[251] = 1'b1;
      f[199:184] = s_l;                          // R7
      f[179:164] = s_r;
    end
    return f;
  endfunction

  function automatic string req_of(input int idx);
    if (fr_idle)   return "R9";
    if (idx >= 240) return "R3";
    if (idx >= 220) return "R4";
    if (idx >= 200) return fr_read ? "R6" : "R5";
    if (idx >= 160) return "R7";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (rst_n) edge_n++;
    s_cv = cmd_valid; s_rd = cmd_rd; s_addr = cmd_addr; s_wd = cmd_wdata;
    s_pv = pcm_valid; s_l = pcm_left; s_r = pcm_right;
  end

  always @(negedge clk) begin
    if (edge_n < 3) begin
      // R10 quiet outputs in and just after reset
      chk(sdata == 1'b0, "R10", "sdata", sdata, 0);
      chk(sync == 1'b0, "R10", "sync", sync, 0);
      chk(cmd_ready == 1'b0, "R10", "cmd_ready", cmd_ready, 0);
      chk(pcm_ready == 1'b0, "R10", "pcm_ready", pcm_ready, 0);
    end else begin
      int pos;
      bit eb;
      pos = (edge_n - 3) % 256;
      if (pos == 0) begin
        logic [255:0] f;
        f = build_frame();
        fr_read = s_cv && s_rd;
        fr_idle = !s_cv && !s_pv;
        exp_q.delete();
        for (int i = 255; i >= 0; i--) exp_q.push_back(f[i]);
      end
      eb = exp_q.pop_front();
      chk(sdata == eb, req_of(255 - pos), $sformatf("sdata bit %0d", 255 - pos), sdata, eb);
      chk(sync == (pos < 16), "R1", $sformatf("sync at %0d", pos), sync, pos < 16);
      chk(cmd_ready == (pos == 0 && s_cv), "R8", "cmd_ready", cmd_ready, pos == 0 && s_cv);
      chk(pcm_ready == (pos == 0 && s_pv), "R8", "pcm_ready", pcm_ready, pos == 0 && s_pv);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_taken(input bit need_cmd, input bit need_pcm);
    bit gc = !need_cmd, gp = !need_pcm;
    while (!(gc && gp)) begin
      @(negedge clk);
      if (cmd_ready) gc = 1;
      if (pcm_ready) gp = 1;
    end
    step(1);
    cmd_valid = 0; pcm_valid = 0;
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_rd = 0; cmd_addr = '0; cmd_wdata = '0;
    pcm_valid = 0; pcm_left = '0; pcm_right = '0;
    step(5);
    rst_n = 1;
    step(300);                                   // R9 idle frames
    // write command and samples together
    cmd_valid = 1; cmd_rd = 0; cmd_addr = 7'h2A; cmd_wdata = 16'hBEEF;
    pcm_valid = 1; pcm_left = 16'h1234; pcm_right = 16'hABCD;
    wait_taken(1, 1);
    step(100);
    // read: write data must vanish (R6)
    cmd_valid = 1; cmd_rd = 1; cmd_addr = 7'h7F; cmd_wdata = 16'hFFFF;
    wait_taken(1, 0);
    // samples alone, extreme values (R7)
    pcm_valid = 1; pcm_left = 16'hFFFF; pcm_right = 16'h8001;
    wait_taken(0, 1);
    // R8 value changed while waiting: the boundary value is sent
    step(50);
    cmd_valid = 1; cmd_rd = 0; cmd_addr = 7'h01; cmd_wdata = 16'h0F0F;
    step(30);
    cmd_wdata = 16'hA5A5; cmd_addr = 7'h40;
    wait_taken(1, 0);
    // R8 data moves mid-frame with no valid: nothing may change
    step(40); pcm_left = 16'h7777; cmd_addr = 7'h55;
    step(600);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule